// File: doc/BRIEF.md
# Dual-Rate Fault Timer Latch

This block guards two power channels that share a single fault timer: a switching regulator with high-side and low-side drivers, and a linear regulator driven through one gate. It takes digitized comparator flags: overvoltage and undervoltage for each channel, and a headroom flag that tells whether the linear pass device has enough voltage across it. A shared accumulator climbs toward one common trip count. It advances on every clock while any overvoltage is present. It advances only once every `UV_DIV` clocks while only undervoltage is present.

When the accumulator reaches the trip count, the block freezes the driver enables into a pattern chosen by the kind of fault. After an overvoltage trip the high side and the linear gate are off and the low side is held on, so that the output is crowbarred. After an undervoltage trip every driver is off. An overcurrent on the linear channel is reported to this block through the linear undervoltage flag, so it uses the slow rate. While no fault is latched, each enable simply passes the regulator's own request. A latched fault is cleared only by the synchronous `clear` input or by the asynchronous `rstN`.

Top module: `fault_timer_latch`

## Requirements
- R1: Overvoltage on either channel (`swOv` or `ldoOv`) that stays asserted for `TRIP_COUNT` consecutive clocks latches a fault on the last of those edges. After `TRIP_COUNT`-1 such clocks, nothing is latched yet.
- R2: Undervoltage on either channel, with no overvoltage, that stays asserted for `TRIP_COUNT`*`UV_DIV` consecutive clocks latches a fault on the last of those edges. After one clock fewer, nothing is latched.
- R3: After an overvoltage trip, `faultKind` is 2'b01, `hsEn`=0, `lsEn`=1 and `ldoEn`=0. This holds whichever channel caused the trip and whatever the requests are.
- R4: After an undervoltage trip, `faultKind` is 2'b10 and `hsEn`, `lsEn` and `ldoEn` are all 0, whatever the requests are.
- R5: While `ldoHeadroomOk` is 0, `ldoUv` has no effect on the timer. When it is 1, `ldoUv` counts at the slow rate like `swUv`.
- R6: A clock with no effective fault flag sets the timer back to zero. The next trip then needs a full uninterrupted window again, and no latch ever occurs without a fault.
- R7: When overvoltage and undervoltage are active together, the timer runs at the fast rate, and the trip gives the overvoltage pattern and code.
- R8: A latched fault and its output pattern hold while fault flags and requests change. A clock edge with `clear`=1 or an assertion of `rstN` low returns `faultKind` to 2'b00.
- R9: While `faultKind` is 2'b00, which is also its value right after reset, `hsEn`, `lsEn` and `ldoEn` equal `hsReq`, `lsReq` and `ldoReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of the latched fault and the timer |
| swOv | input | 1 | Switching channel overvoltage flag |
| swUv | input | 1 | Switching channel undervoltage flag |
| ldoOv | input | 1 | Linear channel overvoltage flag |
| ldoUv | input | 1 | Linear channel undervoltage or overcurrent flag |
| ldoHeadroomOk | input | 1 | 1 when the pass device has enough headroom for undervoltage sensing |
| hsReq | input | 1 | High-side drive request from the regulator loop |
| lsReq | input | 1 | Low-side drive request from the regulator loop |
| ldoReq | input | 1 | Linear gate drive request |
| hsEn | output | 1 | High-side driver enable |
| lsEn | output | 1 | Low-side driver enable |
| ldoEn | output | 1 | Linear gate enable |
| faultKind | output | 2 | 00 none, 01 overvoltage latched, 10 undervoltage latched |

## Verification
The hardest state to reach is a slow-rate trip that sits exactly on its boundary. It needs thousands of uninterrupted undervoltage clocks, and a single clean clock or a gated linear flag in between restarts the whole window. Directed runs hold a flag for exactly one cycle short of the window and then one cycle more. They repeat this with the linear flag masked by low headroom, and with a one-cycle gap in the middle of a fast window. Seeded random segments of mixed flags then run against a cycle model in the bench, so that rate switches and partial windows are compared on every clock.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

  typedef enum logic [1:0] {
    FK_NONE  = 2'b00,
    FK_OVER  = 2'b01,
    FK_UNDER = 2'b10
  } faultKind_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic runFast;
    logic runSlow;
    logic flush;
  } timerStrobe_t;

endpackage

// File: rtl/ftl_timer.sv
module ftl_timer
  import ftl_pkg::*;
#(
  parameter int TRIP_COUNT = 40,
  parameter int UV_DIV     = 50
) (
  input  logic         clk,
  input  logic         rstN,
  input  timerStrobe_t stb,
  output logic         tripNow
);

  localparam int ACC_W = $clog2(TRIP_COUNT + 1);
  localparam int PRE_W = $clog2(UV_DIV + 1);
  localparam logic [ACC_W-1:0] ACC_LAST = ACC_W'(TRIP_COUNT - 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UV_DIV - 1);

  logic [ACC_W-1:0] acc;
  logic [PRE_W-1:0] pre;
  logic slowTick;
  logic accStep;

  assign slowTick = stb.runSlow && (pre == PRE_LAST);
  assign accStep  = !stb.flush && (stb.runFast || slowTick);
  assign tripNow  = accStep && (acc == ACC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      pre <= '0;
    end else if (stb.flush) begin
      acc <= '0;
      pre <= '0;
    end else begin
      if (stb.runFast) begin
        pre <= '0;
      end else if (stb.runSlow) begin
        pre <= slowTick ? '0 : pre + 1'b1;
      end
      if (accStep) begin
        acc <= tripNow ? '0 : acc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ftl_ctrl.sv
module ftl_ctrl
  import ftl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         swOv,
  input  logic         swUv,
  input  logic         ldoOv,
  input  logic         ldoUv,
  input  logic         ldoHeadroomOk,
  input  logic         hsReq,
  input  logic         lsReq,
  input  logic         ldoReq,
  input  logic         tripNow,
  output timerStrobe_t stb,
  output faultKind_t   kind,
  output logic         hsEn,
  output logic         lsEn,
  output logic         ldoEn
);

  logic ovAny;
  logic uvAny;
  logic latched;

  assign ovAny   = swOv | ldoOv;
  assign uvAny   = swUv | (ldoUv & ldoHeadroomOk);
  assign latched = (kind != FK_NONE);

  always_comb begin
    stb.flush   = latched | clear | !(ovAny | uvAny);
    stb.runFast = ovAny & !stb.flush;
    stb.runSlow = uvAny & !ovAny & !stb.flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kind <= FK_NONE;
    end else if (clear) begin
      kind <= FK_NONE;
    end else if (!latched && tripNow) begin
      kind <= stb.runFast ? FK_OVER : FK_UNDER;
    end
  end

  always_comb begin
    unique case (kind)
      FK_OVER: begin
        hsEn  = 1'b0;
        lsEn  = 1'b1;
        ldoEn = 1'b0;
      end
      FK_UNDER: begin
        hsEn  = 1'b0;
        lsEn  = 1'b0;
        ldoEn = 1'b0;
      end
      default: begin
        hsEn  = hsReq;
        lsEn  = lsReq;
        ldoEn = ldoReq;
      end
    endcase
  end

endmodule

// File: rtl/fault_timer_latch.sv
module fault_timer_latch
  import ftl_pkg::*;
#(
  parameter int TRIP_COUNT = 40,
  parameter int UV_DIV     = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       swOv,
  input  logic       swUv,
  input  logic       ldoOv,
  input  logic       ldoUv,
  input  logic       ldoHeadroomOk,
  input  logic       hsReq,
  input  logic       lsReq,
  input  logic       ldoReq,
  output logic       hsEn,
  output logic       lsEn,
  output logic       ldoEn,
  output logic [1:0] faultKind
);

  timerStrobe_t stb;
  faultKind_t   kind;
  logic         tripNow;

  ftl_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .clear         (clear),
    .swOv          (swOv),
    .swUv          (swUv),
    .ldoOv         (ldoOv),
    .ldoUv         (ldoUv),
    .ldoHeadroomOk (ldoHeadroomOk),
    .hsReq         (hsReq),
    .lsReq         (lsReq),
    .ldoReq        (ldoReq),
    .tripNow       (tripNow),
    .stb           (stb),
    .kind          (kind),
    .hsEn          (hsEn),
    .lsEn          (lsEn),
    .ldoEn         (ldoEn)
  );

  ftl_timer #(
    .TRIP_COUNT (TRIP_COUNT),
    .UV_DIV     (UV_DIV)
  ) u_timer (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .tripNow (tripNow)
  );

  assign faultKind = kind;

endmodule

// File: rtl/ftl_checker.sv
module ftl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       clear,
  input logic       swOv,
  input logic       swUv,
  input logic       ldoOv,
  input logic       ldoUv,
  input logic       ldoHeadroomOk,
  input logic       hsReq,
  input logic       lsReq,
  input logic       ldoReq,
  input logic       hsEn,
  input logic       lsEn,
  input logic       ldoEn,
  input logic [1:0] faultKind
);

  // R3
  p_over_pattern_r3: assert property (@(posedge clk) disable iff (!rstN)
    faultKind == 2'b01 |-> (!hsEn && lsEn && !ldoEn));

  // R4
  p_under_pattern_r4: assert property (@(posedge clk) disable iff (!rstN)
    faultKind == 2'b10 |-> (!hsEn && !lsEn && !ldoEn));

  // R8
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultKind != 2'b00 && !clear) |=> faultKind == $past(faultKind));

  // R8
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> faultKind == 2'b00);

  // R9
  p_idle_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultKind == 2'b00 |-> (hsEn == hsReq && lsEn == lsReq && ldoEn == ldoReq));

  // R6
  p_no_fault_no_latch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (faultKind == 2'b00 && !swOv && !ldoOv && !swUv && !(ldoUv && ldoHeadroomOk))
      |=> faultKind == 2'b00);

  // R5
  p_headroom_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    (faultKind == 2'b00 && !swOv && !ldoOv && !swUv && !ldoHeadroomOk)
      |=> faultKind == 2'b00);

  // legal codes only
  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    faultKind != 2'b11);

endmodule

bind fault_timer_latch ftl_checker u_ftl_checker (
  .clk           (clk),
  .rstN          (rstN),
  .clear         (clear),
  .swOv          (swOv),
  .swUv          (swUv),
  .ldoOv         (ldoOv),
  .ldoUv         (ldoUv),
  .ldoHeadroomOk (ldoHeadroomOk),
  .hsReq         (hsReq),
  .lsReq         (lsReq),
  .ldoReq        (ldoReq),
  .hsEn          (hsEn),
  .lsEn          (lsEn),
  .ldoEn         (ldoEn),
  .faultKind     (faultKind)
);

// File: tb/tb_fault_timer_latch.sv
`timescale 1ns/1ps
module tb_fault_timer_latch;

  localparam int TRIP = 40;
  localparam int DIV  = 50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0;
  logic swOv = 1'b0, swUv = 1'b0, ldoOv = 1'b0, ldoUv = 1'b0;
  logic ldoHeadroomOk = 1'b1;
  logic hsReq = 1'b0, lsReq = 1'b0, ldoReq = 1'b0;
  logic hsEn, lsEn, ldoEn;
  logic [1:0] faultKind;

  int checks = 0;
  int fails = 0;

  // bench reference state
  int mAcc = 0;
  int mPre = 0;
  logic [1:0] mKind = 2'b00;

  always #2.5 clk = ~clk;

  fault_timer_latch #(.TRIP_COUNT(TRIP), .UV_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .clear(clear),
    .swOv(swOv), .swUv(swUv), .ldoOv(ldoOv), .ldoUv(ldoUv),
    .ldoHeadroomOk(ldoHeadroomOk),
    .hsReq(hsReq), .lsReq(lsReq), .ldoReq(ldoReq),
    .hsEn(hsEn), .lsEn(lsEn), .ldoEn(ldoEn), .faultKind(faultKind)
  );

  function automatic logic [2:0] expEn(input logic [1:0] k, input logic h, input logic l, input logic d);
    if (k == 2'b01) return 3'b010;
    if (k == 2'b10) return 3'b000;
    return {h, l, d};
  endfunction

  // one clock of the requirement model, using inputs held across the edge
  task automatic modelClock();
    logic ov, uv;
    ov = swOv | ldoOv;
    uv = swUv | (ldoUv & ldoHeadroomOk);
    if (clear) begin
      mKind = 2'b00; mAcc = 0; mPre = 0;
    end else if (mKind != 2'b00 || !(ov || uv)) begin
      mAcc = 0; mPre = 0;
    end else if (ov) begin
      mPre = 0;
      if (mAcc == TRIP - 1) begin mKind = 2'b01; mAcc = 0; end
      else mAcc++;
    end else if (mPre == DIV - 1) begin
      mPre = 0;
      if (mAcc == TRIP - 1) begin mKind = 2'b10; mAcc = 0; end
      else mAcc++;
    end else begin
      mPre++;
    end
  endtask

  task automatic compareOut(input string tag);
    logic [2:0] e;
    e = expEn(mKind, hsReq, lsReq, ldoReq);
    checks++;
    if (faultKind !== mKind || {hsEn, lsEn, ldoEn} !== e) begin
      fails++;
      $display("FAIL %s: kind=%b en=%b expected kind=%b en=%b", tag, faultKind,
               {hsEn, lsEn, ldoEn}, mKind, e);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    modelClock();
    compareOut(tag);
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic checkKind(input logic [1:0] exp, input string tag);
    checks++;
    if (faultKind !== exp) begin
      fails++;
      $display("FAIL %s: kind=%b expected %b", tag, faultKind, exp);
    end
  endtask

  task automatic setFlags(input logic so, input logic su, input logic lo, input logic lu);
    swOv = so; swUv = su; ldoOv = lo; ldoUv = lu;
  endtask

  task automatic doClear(input string tag);
    clear = 1'b1;
    step(tag);
    clear = 1'b0;
    checkKind(2'b00, tag);
  endtask

  task automatic randReq();
    hsReq = 1'($urandom); lsReq = 1'($urandom); ldoReq = 1'($urandom);
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // reset state, R9
    @(negedge clk);
    hsReq = 1'b1; lsReq = 1'b0; ldoReq = 1'b1;
    @(negedge clk);
    compareOut("R9 reset");
    checkKind(2'b00, "R9");
    rstN = 1'b1;
    for (int i = 0; i < 8; i++) begin randReq(); step("R9"); end

    // R1 / R3: linear channel overvoltage trips the switching drivers too
    setFlags(0, 0, 1, 0);
    steps(TRIP - 1, "R1");
    checkKind(2'b00, "R1 window-1");
    step("R3");
    checkKind(2'b01, "R3");
    // R8: hold under changing flags and requests
    for (int i = 0; i < 20; i++) begin
      randReq(); setFlags(1'($urandom), 1'($urandom), 0, 1'($urandom));
      step("R8 hold");
    end
    checkKind(2'b01, "R8 hold");
    setFlags(0, 0, 0, 0);
    doClear("R8 clear");

    // R2 / R4: switching undervoltage, slow rate
    setFlags(0, 1, 0, 0);
    steps(TRIP * DIV - 1, "R2");
    checkKind(2'b00, "R2 window-1");
    step("R4");
    checkKind(2'b10, "R4");
    hsReq = 1; lsReq = 1; ldoReq = 1;
    step("R4 pattern");
    setFlags(0, 0, 0, 0);
    doClear("R8 clear");

    // R5: masked linear undervoltage
    ldoHeadroomOk = 1'b0;
    setFlags(0, 0, 0, 1);
    steps(TRIP * DIV + 100, "R5 masked");
    checkKind(2'b00, "R5 masked");
    ldoHeadroomOk = 1'b1;
    steps(TRIP * DIV - 1, "R5");
    checkKind(2'b00, "R5 window-1");
    step("R5");
    checkKind(2'b10, "R5 unmasked trip");
    setFlags(0, 0, 0, 0);
    doClear("R8 clear");

    // R6: one-clock gap restarts the window
    setFlags(1, 0, 0, 0);
    steps(TRIP - 1, "R6");
    setFlags(0, 0, 0, 0);
    step("R6 gap");
    setFlags(1, 0, 0, 0);
    steps(TRIP - 1, "R6");
    checkKind(2'b00, "R6 restart");
    step("R6");
    checkKind(2'b01, "R6 full window");
    setFlags(0, 0, 0, 0);
    doClear("R8 clear");

    // R7: overvoltage and undervoltage together
    setFlags(0, 1, 1, 1);
    steps(TRIP - 1, "R7");
    checkKind(2'b00, "R7 window-1");
    step("R7");
    checkKind(2'b01, "R7 fast trip");

    // R8: asynchronous reset clears the latch
    setFlags(0, 0, 0, 0);
    #1;
    rstN = 1'b0;
    #1;
    mKind = 2'b00; mAcc = 0; mPre = 0;
    checkKind(2'b00, "R8 async reset");
    @(negedge clk);
    rstN = 1'b1;
    step("R8");

    // random segments against the model
    for (int seg = 0; seg < 150; seg++) begin
      int len;
      int pick;
      len = $urandom_range(1, 70);
      pick = $urandom_range(0, 9);
      randReq();
      ldoHeadroomOk = ($urandom_range(0, 3) != 0);
      case (pick)
        0, 1, 2: setFlags(0, 0, 0, 0);
        3:       setFlags(1'($urandom), 0, 1'($urandom), 0);
        4, 5, 6: setFlags(0, 1'($urandom), 0, 1'($urandom));
        7:       setFlags(1'($urandom), 1, 1'($urandom), 1);
        default: setFlags(0, 1, 0, 0);
      endcase
      clear = ($urandom_range(0, 19) == 0);
      step("R1 random");
      clear = 1'b0;
      steps(len, "R2 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule